// File: doc/BRIEF.md
# Multiplexed Bus Address Splitter and Memory Region Decoder

This block sits between a processor whose low address byte and data share one set of bus lines and the memory and I/O devices on its board. While the address-strobe input is high, the block takes the low address byte from the shared lines and passes it through. When the strobe falls, the block keeps that byte, so the shared lines are free to carry data. The held byte is joined with the high address byte to form a full 16-bit address.

A space-select input marks each cycle as I/O or memory. The block combines it with the active-low read and write controls into four separate active-low strobes: memory read, memory write, I/O read and I/O write. Address bits 15 down to 11 index 2 KB blocks, the smallest device in the map. The first two blocks make up the 4 KB program ROM at 0000h–0FFFh, and the third block is the 2 KB RAM at 1000h–17FFh. The ROM sits at zero because the processor starts fetching there after reset. A behavioural ROM and RAM are included so the whole path can be checked end to end.

Top module: `bus_demux_decoder`

## Requirements
- R1: The low address byte follows `ad_in` while `ale` is high, is registered on each rising clock edge while `ale` is high, and holds its value while `ale` is low. After reset it is 00h.
- R2: `addr` equals `{addr_hi, held low byte}`.
- R3: `mem_rd_n` is low exactly when `io_m`=0, `rd_n`=0 and `wr_n`=1. `mem_wr_n` is low exactly when `io_m`=0, `wr_n`=0 and `rd_n`=1.
- R4: `io_rd_n` is low exactly when `io_m`=1, `rd_n`=0 and `wr_n`=1. `io_wr_n` is low exactly when `io_m`=1, `wr_n`=0 and `rd_n`=1.
- R5: When `rd_n` and `wr_n` are both high, or both low, all four strobes stay high.
- R6: `rom_cs_n` is low when a memory strobe is active and `addr` lies in 0000h–0FFFh (block index 0 or 1).
- R7: `ram_cs_n` is low when a memory strobe is active and `addr` lies in 1000h–17FFh (block index 2).
- R8: For a memory read outside both regions, neither chip select is asserted and `rd_data` reads FFh.
- R9: During an I/O cycle neither chip select is asserted.
- R10: A memory read in the ROM region returns `(A[7:0] XOR {4'b0000, A[11:8]}) XOR 5Ah`.
- R11: A memory write in the RAM region stores the byte on `ad_in` at the rising clock edge. A later memory read of the same address returns that byte. Writes in the ROM region, or during I/O cycles, leave the RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address strobe: high while the shared lines carry the low address byte |
| ad_in | input | 8 | Shared low-address / data lines |
| addr_hi | input | 8 | High address byte |
| io_m | input | 1 | Space select: 1 = I/O, 0 = memory |
| rd_n | input | 1 | Active-low read control |
| wr_n | input | 1 | Active-low write control |
| addr | output | 16 | Full demultiplexed address |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| rom_cs_n | output | 1 | Program ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low |
| rd_data | output | 8 | Read data from the memory model |

## Verification
The bench changes `ad_in` to unrelated data as soon as `ale` falls. A splitter that stopped holding the byte would then let the low address follow the data. The bench also reads the region edges 0FFFh/1000h and 17FFh/1800h, plus block 1 at 0800h. A decoder that used too few upper bits, or the wrong block count, would select the wrong device, or none, at these addresses. I/O cycles are issued at addresses inside RAM, and cycles with read and write both low are issued as well. A design without memory-strobe gating, or without the conflict rule, would then raise a chip select or more than one strobe. RAM read-back after writes at both ends of the RAM, mixed with ROM and I/O writes, would expose wrong offset slicing or writes that reach the RAM when they should not.

// File: rtl/bdd_pkg.sv
package bdd_pkg;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_ROM  = 2'd1,
    REG_RAM  = 2'd2
  } region_e;

  // Active-high internal view of the four separated strobes.
  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
  } strobe_t;

  // Space select plus the two controls give at most one strobe.
  // Both controls low is an illegal combination and yields nothing.
  function automatic strobe_t split_strobes(logic io_m, logic rd_n, logic wr_n);
    strobe_t s;
    logic rd, wr;
    rd = ~rd_n & wr_n;
    wr = ~wr_n & rd_n;
    s.mem_rd = rd & ~io_m;
    s.mem_wr = wr & ~io_m;
    s.io_rd  = rd &  io_m;
    s.io_wr  = wr &  io_m;
    return s;
  endfunction

endpackage

// File: rtl/bdd_addr_capture.sv
module bdd_addr_capture #(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [LO_W-1:0]   ad_in,
  input  logic [HI_W-1:0]   addr_hi,
  output logic [ADDR_W-1:0] addr
);

  logic [LO_W-1:0] lo_q;
  logic [LO_W-1:0] lo_now;

  // Registered copy taken every edge the strobe is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lo_q <= '0;
    else if (ale) lo_q <= ad_in;
  end

  // Pass-through while the strobe is high gives transparent behaviour
  // without an inferred level latch.
  assign lo_now = ale ? ad_in : lo_q;
  assign addr   = {addr_hi, lo_now};

endmodule

// File: rtl/bdd_strobe_gen.sv
module bdd_strobe_gen
  import bdd_pkg::*;
(
  input  logic    io_m,
  input  logic    rd_n,
  input  logic    wr_n,
  output strobe_t strb,
  output logic    mem_rd_n,
  output logic    mem_wr_n,
  output logic    io_rd_n,
  output logic    io_wr_n
);

  assign strb     = split_strobes(io_m, rd_n, wr_n);
  assign mem_rd_n = ~strb.mem_rd;
  assign mem_wr_n = ~strb.mem_wr;
  assign io_rd_n  = ~strb.io_rd;
  assign io_wr_n  = ~strb.io_wr;

endmodule

// File: rtl/bdd_region_decode.sv
module bdd_region_decode
  import bdd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BLK_LOG2 = 11,
  parameter int ROM_BASE = 'h0000,
  parameter int ROM_LOG2 = 12,
  parameter int RAM_BASE = 'h1000,
  parameter int RAM_LOG2 = 11,
  localparam int IDX_W     = ADDR_W - BLK_LOG2,
  localparam int NBLK      = 1 << IDX_W,
  localparam int ROM_FIRST = ROM_BASE >> BLK_LOG2,
  localparam int ROM_BLKS  = 1 << (ROM_LOG2 - BLK_LOG2),
  localparam int RAM_FIRST = RAM_BASE >> BLK_LOG2,
  localparam int RAM_BLKS  = 1 << (RAM_LOG2 - BLK_LOG2)
) (
  input  logic [IDX_W-1:0] blk_idx,
  input  logic             mem_access,
  output region_e          region,
  output logic             rom_cs_n,
  output logic             ram_cs_n
);

  logic [NBLK-1:0] rom_tbl;
  logic [NBLK-1:0] ram_tbl;

  // One decoder output per block; several outputs may feed one device.
  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    assign rom_tbl[g] = (g >= ROM_FIRST) && (g < ROM_FIRST + ROM_BLKS);
    assign ram_tbl[g] = (g >= RAM_FIRST) && (g < RAM_FIRST + RAM_BLKS);
  end

  always_comb begin
    if (rom_tbl[blk_idx])      region = REG_ROM;
    else if (ram_tbl[blk_idx]) region = REG_RAM;
    else                       region = REG_NONE;
  end

  assign rom_cs_n = ~(mem_access && region == REG_ROM);
  assign ram_cs_n = ~(mem_access && region == REG_RAM);

endmodule

// File: rtl/bdd_mem_model.sv
module bdd_mem_model
  import bdd_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ROM_LOG2 = 12,
  parameter int RAM_LOG2 = 11,
  parameter int ROM_SEED = 'h5A,
  parameter int DEF_BYTE = 'hFF,
  localparam int RAM_DEPTH = 1 << RAM_LOG2,
  localparam int WIDE_W    = ROM_LOG2 + DATA_W
) (
  input  logic                clk,
  input  region_e             region,
  input  logic [ROM_LOG2-1:0] rom_off,
  input  logic [RAM_LOG2-1:0] ram_off,
  input  logic                rd_en,
  input  logic                ram_we,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);

  logic [DATA_W-1:0] ram [RAM_DEPTH];

  // Fixed content pattern: low byte, folded with the next byte, plus a seed.
  function automatic logic [DATA_W-1:0] rom_pattern(logic [ROM_LOG2-1:0] off);
    logic [WIDE_W-1:0] wide;
    wide = {{DATA_W{1'b0}}, off};
    return wide[DATA_W-1:0] ^ wide[2*DATA_W-1:DATA_W] ^ DATA_W'(ROM_SEED);
  endfunction

  always_ff @(posedge clk) begin
    if (ram_we) ram[ram_off] <= wdata;
  end

  always_comb begin
    rdata = DATA_W'(DEF_BYTE);
    if (rd_en) begin
      case (region)
        REG_ROM: rdata = rom_pattern(rom_off);
        REG_RAM: rdata = ram[ram_off];
        default: rdata = DATA_W'(DEF_BYTE);
      endcase
    end
  end

endmodule

// File: rtl/bus_demux_decoder.sv
module bus_demux_decoder
  import bdd_pkg::*;
#(
  parameter int LO_W     = 8,
  parameter int HI_W     = 8,
  parameter int BLK_LOG2 = 11,
  parameter int ROM_BASE = 'h0000,
  parameter int ROM_LOG2 = 12,
  parameter int RAM_BASE = 'h1000,
  parameter int RAM_LOG2 = 11,
  localparam int ADDR_W  = LO_W + HI_W,
  localparam int IDX_W   = ADDR_W - BLK_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [LO_W-1:0]   ad_in,
  input  logic [HI_W-1:0]   addr_hi,
  input  logic              io_m,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic [ADDR_W-1:0] addr,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic [LO_W-1:0]   rd_data
);

  strobe_t          strb;
  region_e          region;
  logic             mem_access;
  logic             ram_we;
  logic [IDX_W-1:0] blk_idx;

  bdd_addr_capture #(.LO_W(LO_W), .HI_W(HI_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in),
    .addr_hi(addr_hi), .addr(addr)
  );

  bdd_strobe_gen u_strb (
    .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n), .strb(strb),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
  );

  assign blk_idx    = addr[ADDR_W-1:BLK_LOG2];
  assign mem_access = strb.mem_rd | strb.mem_wr;

  bdd_region_decode #(
    .ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2),
    .ROM_BASE(ROM_BASE), .ROM_LOG2(ROM_LOG2),
    .RAM_BASE(RAM_BASE), .RAM_LOG2(RAM_LOG2)
  ) u_dec (
    .blk_idx(blk_idx), .mem_access(mem_access), .region(region),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n)
  );

  // Named write event, brought out for the checker.
  assign ram_we = strb.mem_wr && (region == REG_RAM);

  bdd_mem_model #(
    .DATA_W(LO_W), .ROM_LOG2(ROM_LOG2), .RAM_LOG2(RAM_LOG2)
  ) u_mem (
    .clk(clk), .region(region),
    .rom_off(addr[ROM_LOG2-1:0]), .ram_off(addr[RAM_LOG2-1:0]),
    .rd_en(strb.mem_rd), .ram_we(ram_we), .wdata(ad_in), .rdata(rd_data)
  );

endmodule

// File: rtl/bdd_checker.sv
module bdd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ale,
  input logic [7:0]  ad_in,
  input logic        io_m,
  input logic        rd_n,
  input logic        wr_n,
  input logic [15:0] addr,
  input logic        mem_rd_n,
  input logic        mem_wr_n,
  input logic        io_rd_n,
  input logic        io_wr_n,
  input logic        rom_cs_n,
  input logic        ram_cs_n,
  input logic [7:0]  rd_data,
  input logic        ram_we
);

  AST_LO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> addr[7:0] == ad_in); // R1

  AST_LO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ale |=> (ale || $stable(addr[7:0]))); // R1

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n})); // R5

  AST_CONFLICT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n) |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n)); // R5

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_cs_n && !ram_cs_n)); // R6

  AST_IO_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    io_m |-> (rom_cs_n && ram_cs_n)); // R9

  AST_UNMAPPED_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n && rom_cs_n && ram_cs_n) |-> rd_data == 8'hFF); // R8

  AST_RAM_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (!ram_cs_n && !mem_wr_n)); // R11

endmodule

bind bus_demux_decoder bdd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .io_m(io_m),
  .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .mem_rd_n(mem_rd_n),
  .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
  .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .rd_data(rd_data),
  .ram_we(ram_we)
);

// File: tb/tb_bus_demux_decoder.sv
module tb_bus_demux_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b0;
  logic [7:0]  ad_in = 8'h00;
  logic [7:0]  addr_hi = 8'h00;
  logic        io_m = 1'b0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [15:0] addr;
  logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
  logic        rom_cs_n, ram_cs_n;
  logic [7:0]  rd_data;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] shadow [2048];
  bit         shadow_v [2048];

  localparam int K_RD = 0, K_WR = 1, K_IDLE = 2, K_BOTH = 3;

  always #4 clk = ~clk;

  bus_demux_decoder dut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_in(ad_in), .addr_hi(addr_hi),
    .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
    .io_wr_n(io_wr_n), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
    .rd_data(rd_data)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 = unmapped, 1 = ROM, 2 = RAM
  function automatic int where(logic [15:0] a);
    if (a <= 16'h0FFF) return 1;
    if (a <= 16'h17FF) return 2;
    return 0;
  endfunction

  function automatic logic [7:0] rom_exp(logic [15:0] a);
    return (a[7:0] ^ {4'b0000, a[11:8]}) ^ 8'h5A;
  endfunction

  task automatic bus_cycle(logic [15:0] a, bit io, int kind, logic [7:0] d);
    bit r, w;
    int reg_id;
    logic [3:0] exp_strb;
    r = (kind == K_RD);
    w = (kind == K_WR);
    reg_id = where(a);
    @(negedge clk);
    ale = 1'b1; ad_in = a[7:0]; addr_hi = a[15:8]; io_m = io;
    rd_n = 1'b1; wr_n = 1'b1;
    #1;
    chk(addr == a, "R1_follow", 32'(addr), 32'(a));
    @(negedge clk);
    ale = 1'b0;
    ad_in = w ? d : 8'($urandom);
    rd_n = !(r || kind == K_BOTH);
    wr_n = !(w || kind == K_BOTH);
    #1;
    chk(addr == a, "R1_hold R2", 32'(addr), 32'(a));
    exp_strb = {!(r && !io), !(w && !io), !(r && io), !(w && io)};
    chk({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} == exp_strb,
        io ? "R4 R5 strobes" : "R3 R5 strobes",
        32'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}), 32'(exp_strb));
    chk(rom_cs_n == !((r || w) && !io && reg_id == 1), "R6 R9 rom_cs",
        32'(rom_cs_n), 32'(!((r || w) && !io && reg_id == 1)));
    chk(ram_cs_n == !((r || w) && !io && reg_id == 2), "R7 R9 ram_cs",
        32'(ram_cs_n), 32'(!((r || w) && !io && reg_id == 2)));
    if (r && !io) begin
      if (reg_id == 1)
        chk(rd_data == rom_exp(a), "R10 rom data", 32'(rd_data), 32'(rom_exp(a)));
      else if (reg_id == 0)
        chk(rd_data == 8'hFF, "R8 default", 32'(rd_data), 32'hFF);
      else if (shadow_v[a[10:0]])
        chk(rd_data == shadow[a[10:0]], "R11 ram data", 32'(rd_data),
            32'(shadow[a[10:0]]));
    end
    if (w && !io && reg_id == 2) begin
      shadow[a[10:0]] = d;
      shadow_v[a[10:0]] = 1'b1;
    end
    @(negedge clk);
    rd_n = 1'b1; wr_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 2048; i++) shadow_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ad_in = 8'hC3;
    @(negedge clk);
    chk(addr[7:0] == 8'h00, "R1 reset", 32'(addr[7:0]), 32'h0);
    chk({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, rom_cs_n, ram_cs_n} == 6'h3F,
        "R5 idle after reset", 32'({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n,
        rom_cs_n, ram_cs_n}), 32'h3F);

    // Directed edges of the map
    bus_cycle(16'h0000, 0, K_RD, 8'h00);   // R6 R10
    bus_cycle(16'h0800, 0, K_RD, 8'h00);   // R6 second ROM block
    bus_cycle(16'h0FFF, 0, K_RD, 8'h00);   // R6
    bus_cycle(16'h1800, 0, K_RD, 8'h00);   // R8
    bus_cycle(16'hFFFF, 0, K_RD, 8'h00);   // R8
    bus_cycle(16'h1000, 0, K_WR, 8'h3C);   // R7 R11
    bus_cycle(16'h17FF, 0, K_WR, 8'hA7);   // R7 R11
    bus_cycle(16'h1000, 0, K_RD, 8'h00);   // R11
    bus_cycle(16'h17FF, 0, K_RD, 8'h00);   // R11
    bus_cycle(16'h1000, 1, K_WR, 8'h99);   // R4 R9: must not reach RAM
    bus_cycle(16'h1000, 1, K_RD, 8'h00);   // R4 R9
    bus_cycle(16'h1000, 0, K_RD, 8'h00);   // R11 unchanged after I/O write
    bus_cycle(16'h1000, 0, K_BOTH, 8'h00); // R5 conflict
    bus_cycle(16'h0123, 1, K_BOTH, 8'h00); // R5 conflict on I/O side
    bus_cycle(16'h0456, 0, K_IDLE, 8'h00); // R5 idle
    bus_cycle(16'h0456, 0, K_WR, 8'h11);   // R6 write cycle to ROM
    bus_cycle(16'h0456, 0, K_RD, 8'h00);   // R10 ROM unchanged

    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      int k;
      bit io;
      a  = ($urandom % 4 != 0) ? 16'($urandom % 32'h2000) : 16'($urandom);
      k  = $urandom % 8;
      k  = (k < 4) ? K_RD : (k < 6) ? K_WR : (k == 6) ? K_IDLE : K_BOTH;
      io = ($urandom % 4 == 0);
      bus_cycle(a, io, k, 8'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule